// File: doc/BRIEF.md
# Divided-Clock SPI Master Serial Engine

This block is the serial engine of an SPI master. It runs from an on-chip reference clock and derives the serial clock from a programmable divide value. One start strobe sends one word of programmable length and receives one word at the same time. At start the engine drives an active-low slave select. It then waits one full serial period and toggles the serial clock once per bit. Outgoing data changes on falling serial edges. Incoming data is captured on rising edges. After the last bit the engine releases the data line and raises the select.

The divide value, word length and transmit word are captured in the cycle the start strobe is accepted. Changes to them during a transfer have no effect until the next start. When the divide value is even and nonzero, the high phase of the serial clock is two reference cycles longer than the low phase. Otherwise the two phases are equal. A one-cycle done pulse marks the reference cycle in which the received word becomes valid and the select returns high.

Top module: `spi_div_master`

## Requirements
- R1: With D the captured divide value, each serial-clock high phase lasts H reference cycles and each low phase between two rising edges lasts L cycles. For D zero or odd, H = L = D+1. For D even and nonzero, L = D and H = D+2. The period is therefore 2(D+1).
- R2: The serial clock idles low and is high only while the select is low.
- R3: The select goes low in the cycle after an accepted start. The first rising edge follows one full period, 2(D+1) cycles, later. The select stays low for (N+1)·2(D+1) cycles, where N is the effective word length.
- R4: The data-output enable rises H cycles after the select falls. Data out is stable while the serial clock is high, and the enable is high only while the select is low.
- R5: Data in is captured at each rising serial edge. After a transfer, the receive word holds the N captured bits in its low N bits, first captured bit at bit N-1, with zeros above.
- R6: The transmit word is sent from bit N-1 down to bit 0. The length input is clamped to the range 8 to 32, so 4 sends 8 bits and 40 sends 32 bits.
- R7: The data-output enable falls in the same cycle as the final falling serial edge. The select returns high L cycles after that edge.
- R8: Done is high for exactly one reference cycle, the first cycle with the select high again after a transfer.
- R9: A start strobe during a transfer is ignored, and so are changes to the divide value, length or transmit word. The transfer in progress keeps its bits and timing, and only one done pulse follows.
- R10: While reset is asserted, and in the cycle after it, the serial clock is low, the select is high, the output enable is low and done is low. Reset in mid-transfer aborts the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Serial clock divide value D |
| len_i | input | LEN_W | Word length in bits (clamped 8..32) |
| start_i | input | 1 | Start strobe, taken only when idle |
| tx_data_i | input | MAX_LEN | Word to transmit, right-aligned |
| rx_data_o | output | MAX_LEN | Received word, right-aligned |
| done_o | output | 1 | One-cycle pulse: receive word valid |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The embedded properties assume that data in is already synchronous to the reference clock and changes only away from the reference edge at which a rising serial edge is issued. The bench meets this with a slave model that updates data in on the reference clock's falling edge, after a serial falling edge or select fall. The properties also assume that the start strobe lasts one reference cycle when the engine is idle. The bench raises it for exactly one cycle and raises any extra strobes only in the middle of a transfer.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD_H,
    PH_LEAD_L,
    PH_HIGH,
    PH_LOW,
    PH_TAIL
  } phase_e;

endpackage

// File: rtl/spi_div_phase_calc.sv
module spi_div_phase_calc #(
  parameter int DIV_W = 8,
  localparam int CW = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [CW-1:0]    lo_w_o,
  output logic [CW-1:0]    hi_w_o
);

  logic [CW-1:0] d;
  logic          sym;

  assign d   = CW'(div_i);
  assign sym = (div_i == '0) || div_i[0];

  // even nonzero divide: high phase gets the extra reference cycle pair
  always_comb begin
    if (sym) begin
      lo_w_o = d + CW'(1);
      hi_w_o = d + CW'(1);
    end else begin
      lo_w_o = d;
      hi_w_o = d + CW'(2);
    end
  end

endmodule

// File: rtl/spi_div_shifter.sv
module spi_div_shifter #(
  parameter int MAX_LEN = 32,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [MAX_LEN-1:0] tx_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               shift_i,
  input  logic               sample_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic [MAX_LEN-1:0] rx_o
);

  logic [MAX_LEN-1:0] tx_sh;
  logic [MAX_LEN-1:0] rx_sh;
  int unsigned        align;

  assign align = MAX_LEN - int'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load_i) begin
        tx_sh <= tx_i << align;   // MSB of the word to the top
        rx_sh <= '0;
      end else begin
        if (shift_i)  tx_sh <= {tx_sh[MAX_LEN-2:0], 1'b0};
        if (sample_i) rx_sh <= {rx_sh[MAX_LEN-2:0], sdi_i};
      end
    end
  end

  assign sdo_o = tx_sh[MAX_LEN-1];
  assign rx_o  = rx_sh;

  a_r5_no_load_and_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !sample_i && !shift_i);

endmodule

// File: rtl/spi_div_ctrl.sv
module spi_div_ctrl
  import spi_div_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int MAX_LEN = 32,
  localparam int CW = DIV_W + 1,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             oe_o,
  output logic             done_o
);

  phase_e           st;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    lo_q, hi_q;
  logic [CW-1:0]    lo_w, hi_w;
  logic [LEN_W-1:0] bits_left;
  logic             cnt_zero;
  logic             sclk_q, cs_n_q, oe_q, done_q;

  spi_div_phase_calc #(.DIV_W(DIV_W)) u_calc (
    .div_i  (div_i),
    .lo_w_o (lo_w),
    .hi_w_o (hi_w)
  );

  assign cnt_zero = (cnt == '0);
  assign load_o   = (st == PH_IDLE) && start_i;
  assign sample_o = ((st == PH_LEAD_L) || (st == PH_LOW)) && cnt_zero;
  assign shift_o  = (st == PH_HIGH) && cnt_zero && (bits_left != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      bits_left <= '0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!cnt_zero) cnt <= cnt - CW'(1);
      unique case (st)
        PH_IDLE: begin
          if (start_i) begin
            st        <= PH_LEAD_H;
            cs_n_q    <= 1'b0;
            cnt       <= hi_w - CW'(1);
            lo_q      <= lo_w;
            hi_q      <= hi_w;
            bits_left <= len_i - LEN_W'(1);
          end
        end
        PH_LEAD_H: if (cnt_zero) begin
          st   <= PH_LEAD_L;
          oe_q <= 1'b1;
          cnt  <= lo_q - CW'(1);
        end
        PH_LEAD_L, PH_LOW: if (cnt_zero) begin
          st     <= PH_HIGH;
          sclk_q <= 1'b1;
          cnt    <= hi_q - CW'(1);
        end
        PH_HIGH: if (cnt_zero) begin
          sclk_q <= 1'b0;
          cnt    <= lo_q - CW'(1);
          if (bits_left != '0) begin
            st        <= PH_LOW;
            bits_left <= bits_left - LEN_W'(1);
          end else begin
            st   <= PH_TAIL;
            oe_q <= 1'b0;
          end
        end
        PH_TAIL: if (cnt_zero) begin
          st     <= PH_IDLE;
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign cs_no  = cs_n_q;
  assign oe_o   = oe_q;
  assign done_o = done_q;

  // independent run-length of the high phase
  logic [CW:0] hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_run <= '0;
    else if (sclk_q) hi_run <= hi_run + (CW+1)'(1);
    else             hi_run <= '0;
  end

  a_r1_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_q) |-> hi_run == {1'b0, hi_q});

  a_r2_sclk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> !cs_n_q);

  a_r4_oe_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> !cs_n_q);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r8_done_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cs_n_q && $past(!cs_n_q));

  a_r7_oe_off_before_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_q) |-> !oe_q && !sclk_q);

endmodule

// File: rtl/spi_div_master.sv
module spi_div_master #(
  parameter int DIV_W = 8,
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 32,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               start_i,
  input  logic [MAX_LEN-1:0] tx_data_i,
  output logic [MAX_LEN-1:0] rx_data_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  output logic               mosi_oe_o,
  input  logic               miso_i
);

  logic [LEN_W-1:0] len_eff;
  logic             load, shift, sample, sdo;

  always_comb begin
    if (len_i < LEN_W'(MIN_LEN))      len_eff = LEN_W'(MIN_LEN);
    else if (len_i > LEN_W'(MAX_LEN)) len_eff = LEN_W'(MAX_LEN);
    else                              len_eff = len_i;
  end

  spi_div_ctrl #(.DIV_W(DIV_W), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .div_i    (div_i),
    .len_i    (len_eff),
    .load_o   (load),
    .shift_o  (shift),
    .sample_o (sample),
    .sclk_o   (sclk_o),
    .cs_no    (cs_no),
    .oe_o     (mosi_oe_o),
    .done_o   (done_o)
  );

  spi_div_shifter #(.MAX_LEN(MAX_LEN)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .tx_i     (tx_data_i),
    .len_i    (len_eff),
    .shift_i  (shift),
    .sample_i (sample),
    .sdi_i    (miso_i),
    .sdo_o    (sdo),
    .rx_o     (rx_data_o)
  );

  assign mosi_o = sdo;

  a_r4_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o));

  a_r6_len_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_eff >= LEN_W'(MIN_LEN) && len_eff <= LEN_W'(MAX_LEN));

endmodule

// File: tb/spi_div_master_tb.sv
module spi_div_master_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  div_i = '0;
  logic [5:0]  len_i = 6'd8;
  logic        start_i = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic [31:0] rx_data_o;
  logic        done_o, sclk_o, cs_no, mosi_o, mosi_oe_o;
  logic        miso_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;   // 125 MHz

  spi_div_master dut_i (
    .clk_i, .rst_ni, .div_i, .len_i, .start_i, .tx_data_i, .rx_data_o,
    .done_o, .sclk_o, .cs_no, .mosi_o, .mosi_oe_o, .miso_i
  );

  // div[79:72] len[71:64] tx[63:32] slave[31:0]
  localparam logic [79:0] VEC [6] = '{
    {8'd0, 8'd8,  32'h0000_00A5, 32'h0000_003C},
    {8'd1, 8'd13, 32'h0000_1B6D, 32'h0000_0A5F},
    {8'd2, 8'd32, 32'hDEAD_BEEF, 32'h1234_5678},
    {8'd3, 8'd16, 32'h0000_8001, 32'h0000_7FFE},
    {8'd4, 8'd8,  32'h0000_005A, 32'h0000_00C3},
    {8'd7, 8'd24, 32'h00F0_0F55, 32'h00AA_55CC}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic run_xfer(input int dv, input int ln, input logic [31:0] tx,
                          input logic [31:0] slv, input bit inj);
    int el, hw, lw, tp, t, idx, rises, last_fall, hi_run, lo_run, hi_bad, lo_bad;
    int oe_rise, oe_fall, lead;
    logic [31:0] cap;
    logic ps, po, pc, got_done;
    el = (ln < 8) ? 8 : (ln > 32) ? 32 : ln;
    hw = (dv == 0 || dv % 2 == 1) ? dv + 1 : dv + 2;
    lw = (dv == 0 || dv % 2 == 1) ? dv + 1 : dv;
    tp = 2 * (dv + 1);
    @(negedge clk_i);
    div_i = 8'(dv); len_i = 6'(ln); tx_data_i = tx; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    t = 0; rises = 0; last_fall = 0; hi_run = 0; lo_run = 0; hi_bad = 0; lo_bad = 0;
    oe_rise = -1; oe_fall = -1; lead = -1; cap = '0; got_done = 0;
    ps = 1'b0; po = 1'b0; pc = 1'b1;
    while (t < 5000) begin
      if (pc && !cs_no) begin idx = el - 1; miso_i = slv[idx]; end
      if (!ps && sclk_o) begin
        if (rises == 0) lead = t;
        else if (lo_run != lw) lo_bad++;
        rises++;
        cap = {cap[30:0], mosi_o};
        hi_run = 0;
      end
      if (ps && !sclk_o) begin
        if (hi_run != hw) hi_bad++;
        last_fall = t; lo_run = 0;
        idx--; if (idx >= 0) miso_i = slv[idx];
      end
      if (sclk_o) hi_run++; else lo_run++;
      if (!po && mosi_oe_o) oe_rise = t;
      if (po && !mosi_oe_o) oe_fall = t;
      if (inj && t == tp + 3) begin
        start_i = 1'b1; tx_data_i = ~tx; div_i = 8'(dv + 1); len_i = 6'd32;
      end else start_i = 1'b0;
      if (!pc && cs_no) begin got_done = done_o; break; end
      ps = sclk_o; po = mosi_oe_o; pc = cs_no;
      @(negedge clk_i); t++;
    end
    chk(t < 5000, "R3 frame end", t, 5000);
    chk(lead == tp, "R3 lead period", lead, tp);
    chk(t == (el + 1) * tp, "R3 select low length", t, (el + 1) * tp);
    chk(oe_rise == hw, "R4 first bit valid", oe_rise, hw);
    chk(hi_bad == 0 && lo_bad == 0, "R1 phase widths", hi_bad + lo_bad, 0);
    chk(rises == el, "R2 clock count", rises, el);
    chk(cap == (tx & mask(el)), "R6 msb-first data", cap, tx & mask(el));
    chk(rx_data_o == (slv & mask(el)), "R5 received word", rx_data_o, slv & mask(el));
    chk(oe_fall == last_fall, "R7 oe release", oe_fall, last_fall);
    chk(t - last_fall == lw, "R7 select rise", t - last_fall, lw);
    chk(got_done == 1'b1, "R8 done at select rise", got_done, 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    if (inj) begin
      repeat (3 * tp) begin
        @(negedge clk_i);
        if (done_o || !cs_no) break;
      end
      chk(cs_no && !done_o, "R9 busy start ignored", {cs_no, done_o}, 2'b10);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!sclk_o && cs_no && !mosi_oe_o && !done_o, "R10 in reset",
        {sclk_o, cs_no, mosi_oe_o, done_o}, 4'b0100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!sclk_o && cs_no && !mosi_oe_o && !done_o, "R10 after reset",
        {sclk_o, cs_no, mosi_oe_o, done_o}, 4'b0100);

    foreach (VEC[i]) begin
      run_xfer(int'(VEC[i][79:72]), int'(VEC[i][71:64]), VEC[i][63:32], VEC[i][31:0], 1'b0);
    end

    // R6 clamping
    run_xfer(2, 4, 32'h0000_01C7, 32'h0000_0099, 1'b0);
    run_xfer(1, 40, 32'hA5A5_0FF0, 32'h5A5A_F00F, 1'b0);
    // R9 start and settings ignored mid-transfer
    run_xfer(3, 12, 32'h0000_0ABC, 32'h0000_0531, 1'b1);
    run_xfer(6, 8, 32'h0000_0081, 32'h0000_00FF, 1'b1);

    // R10 reset during a transfer
    @(negedge clk_i);
    div_i = 8'd2; len_i = 6'd16; tx_data_i = 32'hFFFF; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!sclk_o && cs_no && !mosi_oe_o && !done_o, "R10 abort",
        {sclk_o, cs_no, mosi_oe_o, done_o}, 4'b0100);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk(cs_no && !sclk_o, "R10 stays idle", {cs_no, sclk_o}, 2'b10);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule